// File: doc/BRIEF.md
# Data Access Translation and Permission Checker

This block holds the decision logic for loads and stores that sits next to a translation lookaside buffer. Each request presents a virtual address, a size code, a store flag and three request qualifiers: physical-mode, alternate-mode and page-table fetch. The block forms the lookup page number for the external buffer. It takes the buffer's hit, page number and per-mode enables back in the same cycle. One cycle later it returns a physical address, an uncacheable flag, and either success or a one-hot fault code with a status word.

The checks run in a fixed order. Alignment comes first. Then the physical-mode bypass, then canonical-address validity, then the kernel-only direct-mapped window, and then buffer hit or miss. On a hit, the mode-mask permission check runs before the fault-on bits. The final physical-address range check and the cacheability decode are applied last, to whatever address the chosen path produced. The effective privilege mode for permission checks comes from the current mode, except in privileged code. Privileged code runs as kernel unless it asks for the alternate mode.

Top module: `dtx_xlate_check`

## Requirements
- R1: When the address bits below the access size are not all zero, the response is an alignment fault (resp_fault bit 0) ahead of every other check. The access size is 1<<req_size_log2 bytes. The status word then carries only the store bit (resp_status bit 0), set for stores.
- R2: With the physical-mode flag, the physical address equals the virtual address, and no validity, window, miss or permission fault can occur.
- R3: An address whose bits 63:42 are neither all zero nor all one gives a page fault (resp_fault bit 1). Its status has bad-address (bit 5) and access-violation (bit 1) set, plus the store bit for stores.
- R4: An address with bits 47:41 equal to 0x7e is direct mapped. The address is masked to bits 43:0. If bit 40 is set, bits 43:40 are then set; otherwise the address is truncated to bits 39:0.
- R5: A direct-mapped access whose current mode (cur_mode) is not kernel (0) gives an access-violation fault (resp_fault bit 2). Its status is access-violation plus the store bit.
- R6: A buffer miss sets status bit 4 and the store bit. The fault is the page-table miss (resp_fault bit 3) when req_pte_fetch is set, and the normal miss (bit 4) otherwise.
- R7: On a hit, the physical address is tlb_ppn shifted left by 13 plus address bits 12:0. lookup_vpn always equals address bits 42:13.
- R8: A store whose write enable for the effective mode (bit 1<<mode) is clear gives a page fault. Its status is store, access-violation and, if fault-on-write is set, fault-on-write (bit 3). A load whose read enable is clear gives an access-violation fault with status access-violation plus fault-on-read (bit 2) if that is set.
- R9: When the enable check passes but the fault-on bit for the access direction is set, the response is a page fault. Its status holds only that fault-on bit plus the store bit.
- R10: The effective mode is cur_mode outside privileged code. In privileged code it is kernel, or alt_mode when req_alt is set.
- R11: A final physical address with any bit above 43 set gives a machine check (resp_fault bit 5) with an all-zero status.
- R12: Otherwise, physical bit 43 set marks the access uncacheable and clears bits 42:35 of the returned address.
- R13: A request's response appears with resp_valid one cycle later. resp_fault has at most one bit set, and resp_ok is high exactly when it has none.
- R14: During reset resp_valid and resp_fault are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_vaddr | input | VA_W | Virtual address |
| req_size_log2 | input | SZ_W | Log2 of access size in bytes |
| req_store | input | 1 | Store when set, load otherwise |
| req_phys | input | 1 | Physical-mode request |
| req_alt | input | 1 | Use alternate mode in privileged code |
| req_pte_fetch | input | 1 | Request is a page-table fetch |
| cur_mode | input | MODE_W | Current processor mode, 0 = kernel |
| priv_code | input | 1 | Executing privileged code |
| alt_mode | input | MODE_W | Alternate mode value |
| lookup_vpn | output | VPN_W | Page number presented to the buffer |
| tlb_hit | input | 1 | Buffer hit |
| tlb_ppn | input | PPN_W | Physical page number of the hit |
| tlb_rd_en | input | NMODE | Read enable per mode |
| tlb_wr_en | input | NMODE | Write enable per mode |
| tlb_fo_rd | input | 1 | Fault-on-read bit |
| tlb_fo_wr | input | 1 | Fault-on-write bit |
| resp_valid | output | 1 | Response present |
| resp_ok | output | 1 | Access succeeded |
| resp_pa | output | VA_W | Physical address (meaningless on a fault) |
| resp_uncached | output | 1 | Access is uncacheable |
| resp_fault | output | 6 | One-hot fault code |
| resp_status | output | 6 | Memory-management status word |

## Verification
The enable check and the fault-on check can both trigger on the same access. When that happens, the violation must win the fault code, yet both flags must appear in the status word. The alternate-mode remapping changes which enable bit decides the outcome in that same cycle. The bench provokes the combination by sweeping every enable mask against both fault-on bits, all current and alternate modes and both privilege settings. It judges each response against an arithmetic restatement of the priority order. A second pairing also falls in one response: machine check and uncacheable decode on one physical address. A single-bit sweep of the physical address and of the page number drives that pairing.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

  localparam int unsigned FLT_N = 6;
  localparam int unsigned MMS_N = 6;
  localparam int unsigned MODE_KERNEL = 0;

  // one-hot fault code bit positions
  typedef enum int unsigned {
    FLT_ALIGN    = 0,
    FLT_PAGE     = 1,
    FLT_ACV      = 2,
    FLT_MISS_PTE = 3,
    FLT_MISS_NRM = 4,
    FLT_MCHK     = 5
  } flt_idx_e;

  // status word bit positions
  typedef enum int unsigned {
    MMS_WR    = 0,
    MMS_ACV   = 1,
    MMS_FONR  = 2,
    MMS_FONW  = 3,
    MMS_MISS  = 4,
    MMS_BADVA = 5
  } mms_idx_e;

  typedef struct packed {
    logic [FLT_N-1:0] fault;
    logic [MMS_N-1:0] stat;
  } dtx_verdict_t;

endpackage

// File: rtl/dtx_perm_check.sv
module dtx_perm_check
  import dtx_pkg::*;
#(
  parameter int unsigned NMODE  = 4,
  localparam int unsigned MODE_W = $clog2(NMODE)
) (
  input  logic              is_store,
  input  logic [MODE_W-1:0] eff_mode,
  input  logic [NMODE-1:0]  rd_en,
  input  logic [NMODE-1:0]  wr_en,
  input  logic              fo_rd,
  input  logic              fo_wr,
  output logic              perm_deny,
  output logic              fo_trip,
  output dtx_verdict_t      verdict
);

  logic [NMODE-1:0] sel_en;
  logic             sel_fo;
  logic             mode_bit;

  // per-mode enable pick, one lane per mode
  logic [NMODE-1:0] lane_hit;
  for (genvar g = 0; g < NMODE; g++) begin : g_lane
    assign lane_hit[g] = (eff_mode == MODE_W'(g)) && sel_en[g];
  end

  always_comb begin
    sel_en   = is_store ? wr_en : rd_en;
    sel_fo   = is_store ? fo_wr : fo_rd;
    mode_bit = |lane_hit;
    perm_deny = !mode_bit;
    fo_trip   = mode_bit && sel_fo;
  end

  always_comb begin
    verdict = '0;
    if (perm_deny) begin
      verdict.fault[is_store ? FLT_PAGE : FLT_ACV] = 1'b1;
      verdict.stat[MMS_ACV]  = 1'b1;
      verdict.stat[MMS_WR]   = is_store;
      verdict.stat[MMS_FONW] = is_store && fo_wr;
      verdict.stat[MMS_FONR] = !is_store && fo_rd;
    end else if (fo_trip) begin
      verdict.fault[FLT_PAGE] = 1'b1;
      verdict.stat[MMS_WR]    = is_store;
      verdict.stat[MMS_FONW]  = is_store;
      verdict.stat[MMS_FONR]  = !is_store;
    end
  end

endmodule

// File: rtl/dtx_direct_map.sv
module dtx_direct_map #(
  parameter int unsigned VA_W   = 64,
  parameter int unsigned PA_W   = 44,
  parameter int unsigned SP_HI  = 47,
  parameter int unsigned SP_LO  = 41,
  parameter int unsigned SP_TAG = 'h7e,
  parameter int unsigned SX_BIT = 40
) (
  input  logic [VA_W-1:0] va,
  output logic            sp_hit,
  output logic [VA_W-1:0] sp_pa
);

  localparam int unsigned SP_W = SP_HI - SP_LO + 1;
  localparam logic [VA_W-1:0] IMPL_MASK = (VA_W'(1) << PA_W) - VA_W'(1);
  localparam logic [VA_W-1:0] SX_KEEP   = (VA_W'(1) << SX_BIT) - VA_W'(1);
  localparam logic [VA_W-1:0] SX_FILL   = IMPL_MASK & ~SX_KEEP;

  logic [VA_W-1:0] masked;

  always_comb begin
    sp_hit = (va[SP_HI:SP_LO] == SP_W'(SP_TAG));
    masked = va & IMPL_MASK;
    sp_pa  = masked[SX_BIT] ? (masked | SX_FILL) : (masked & SX_KEEP);
  end

endmodule

// File: rtl/dtx_pa_finish.sv
module dtx_pa_finish #(
  parameter int unsigned VA_W      = 64,
  parameter int unsigned PA_W      = 44,
  parameter int unsigned UC_CLR_HI = 42,
  parameter int unsigned UC_CLR_LO = 35
) (
  input  logic [VA_W-1:0] pa_raw,
  output logic            mchk,
  output logic            uncached,
  output logic [VA_W-1:0] pa_out
);

  localparam int unsigned UC_BIT = PA_W - 1;
  localparam logic [VA_W-1:0] IMPL_MASK = (VA_W'(1) << PA_W) - VA_W'(1);
  localparam logic [VA_W-1:0] CLR_MASK  =
    ((VA_W'(1) << (UC_CLR_HI + 1)) - VA_W'(1)) & ~((VA_W'(1) << UC_CLR_LO) - VA_W'(1));

  always_comb begin
    mchk     = |(pa_raw & ~IMPL_MASK);
    uncached = !mchk && pa_raw[UC_BIT];
    pa_out   = uncached ? (pa_raw & ~CLR_MASK) : pa_raw;
  end

endmodule

// File: rtl/dtx_xlate_check.sv
module dtx_xlate_check
  import dtx_pkg::*;
#(
  parameter int unsigned VA_W       = 64,
  parameter int unsigned VA_IMPL    = 43,
  parameter int unsigned PA_W       = 44,
  parameter int unsigned PAGE_SHIFT = 13,
  parameter int unsigned PPN_W      = 32,
  parameter int unsigned NMODE      = 4,
  parameter int unsigned SZ_W       = 2,
  localparam int unsigned MODE_W    = $clog2(NMODE),
  localparam int unsigned VPN_W     = VA_IMPL - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [SZ_W-1:0]   req_size_log2,
  input  logic              req_store,
  input  logic              req_phys,
  input  logic              req_alt,
  input  logic              req_pte_fetch,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic              priv_code,
  input  logic [MODE_W-1:0] alt_mode,
  output logic [VPN_W-1:0]  lookup_vpn,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  tlb_ppn,
  input  logic [NMODE-1:0]  tlb_rd_en,
  input  logic [NMODE-1:0]  tlb_wr_en,
  input  logic              tlb_fo_rd,
  input  logic              tlb_fo_wr,
  output logic              resp_valid,
  output logic              resp_ok,
  output logic [VA_W-1:0]   resp_pa,
  output logic              resp_uncached,
  output logic [FLT_N-1:0]  resp_fault,
  output logic [MMS_N-1:0]  resp_status
);

  localparam int unsigned ALN_W     = (1 << SZ_W) - 1;
  localparam int unsigned UC_BIT    = PA_W - 1;
  localparam int unsigned UC_CLR_HI = PA_W - 2;
  localparam int unsigned UC_CLR_LO = PA_W - 9;

  // ---------------- arithmetic helpers ----------------
  function automatic logic f_misaligned(input logic [ALN_W-1:0] low,
                                        input logic [SZ_W-1:0]  sz);
    logic [ALN_W-1:0] span;
    span = (ALN_W'(1) << sz) - ALN_W'(1);
    return (low & span) != '0;
  endfunction

  function automatic logic f_va_canon(input logic [VA_W-1:0] va);
    logic [VA_W-VA_IMPL:0] hi;
    hi = va[VA_W-1:VA_IMPL-1];
    return (hi == '0) || (&hi);
  endfunction

  function automatic logic [VA_W-1:0] f_hit_pa(input logic [PPN_W-1:0] ppn,
                                               input logic [VA_W-1:0]  va);
    logic [VA_W-1:0] base;
    logic [VA_W-1:0] ofs;
    base = {{(VA_W-PPN_W){1'b0}}, ppn} << PAGE_SHIFT;
    ofs  = {{(VA_W-PAGE_SHIFT){1'b0}}, va[PAGE_SHIFT-1:0]};
    return base + ofs;
  endfunction

  function automatic logic [MODE_W-1:0] f_eff_mode(input logic              priv,
                                                   input logic              alt,
                                                   input logic [MODE_W-1:0] cur,
                                                   input logic [MODE_W-1:0] altm);
    if (!priv)    return cur;
    else if (alt) return altm;
    else          return MODE_W'(MODE_KERNEL);
  endfunction

  // ---------------- named internal events ----------------
  logic              ev_misalign;
  logic              ev_badva;
  logic              ev_sp;
  logic              ev_sp_deny;
  logic              ev_miss;
  logic              ev_perm_deny;
  logic              ev_fo_trip;
  logic              ev_mchk;
  logic              ev_uncached;
  logic [MODE_W-1:0] eff_mode;
  logic [VA_W-1:0]   sp_pa;
  logic [VA_W-1:0]   pa_raw;
  logic [VA_W-1:0]   pa_fin;
  dtx_verdict_t      perm_verdict;
  dtx_verdict_t      pre_verdict;
  dtx_verdict_t      fin_verdict;
  logic              use_perm;

  assign lookup_vpn = req_vaddr[VA_IMPL-1:PAGE_SHIFT];
  assign eff_mode   = f_eff_mode(priv_code, req_alt, cur_mode, alt_mode);

  dtx_direct_map #(
    .VA_W  (VA_W),
    .PA_W  (PA_W),
    .SP_HI (47),
    .SP_LO (41),
    .SP_TAG('h7e),
    .SX_BIT(40)
  ) u_direct_map (
    .va    (req_vaddr),
    .sp_hit(ev_sp),
    .sp_pa (sp_pa)
  );

  dtx_perm_check #(
    .NMODE(NMODE)
  ) u_perm_check (
    .is_store (req_store),
    .eff_mode (eff_mode),
    .rd_en    (tlb_rd_en),
    .wr_en    (tlb_wr_en),
    .fo_rd    (tlb_fo_rd),
    .fo_wr    (tlb_fo_wr),
    .perm_deny(ev_perm_deny),
    .fo_trip  (ev_fo_trip),
    .verdict  (perm_verdict)
  );

  // ---------------- priority chain ----------------
  always_comb begin
    pre_verdict = '0;
    pa_raw      = req_vaddr;
    use_perm    = 1'b0;
    ev_misalign = f_misaligned(req_vaddr[ALN_W-1:0], req_size_log2);
    ev_badva    = 1'b0;
    ev_sp_deny  = 1'b0;
    ev_miss     = 1'b0;
    if (ev_misalign) begin
      pre_verdict.fault[FLT_ALIGN] = 1'b1;
      pre_verdict.stat[MMS_WR]     = req_store;
    end else if (req_phys) begin
      pa_raw = req_vaddr;
    end else if (!f_va_canon(req_vaddr)) begin
      ev_badva = 1'b1;
      pre_verdict.fault[FLT_PAGE]  = 1'b1;
      pre_verdict.stat[MMS_BADVA]  = 1'b1;
      pre_verdict.stat[MMS_ACV]    = 1'b1;
      pre_verdict.stat[MMS_WR]     = req_store;
    end else if (ev_sp) begin
      if (cur_mode != MODE_W'(MODE_KERNEL)) begin
        ev_sp_deny = 1'b1;
        pre_verdict.fault[FLT_ACV] = 1'b1;
        pre_verdict.stat[MMS_ACV]  = 1'b1;
        pre_verdict.stat[MMS_WR]   = req_store;
      end else begin
        pa_raw = sp_pa;
      end
    end else if (!tlb_hit) begin
      ev_miss = 1'b1;
      pre_verdict.fault[req_pte_fetch ? FLT_MISS_PTE : FLT_MISS_NRM] = 1'b1;
      pre_verdict.stat[MMS_MISS] = 1'b1;
      pre_verdict.stat[MMS_WR]   = req_store;
    end else begin
      pa_raw   = f_hit_pa(tlb_ppn, req_vaddr);
      use_perm = 1'b1;
      pre_verdict = perm_verdict;
    end
  end

  dtx_pa_finish #(
    .VA_W     (VA_W),
    .PA_W     (PA_W),
    .UC_CLR_HI(UC_CLR_HI),
    .UC_CLR_LO(UC_CLR_LO)
  ) u_pa_finish (
    .pa_raw  (pa_raw),
    .mchk    (ev_mchk),
    .uncached(ev_uncached),
    .pa_out  (pa_fin)
  );

  always_comb begin
    fin_verdict = pre_verdict;
    if (pre_verdict.fault == '0 && ev_mchk) begin
      fin_verdict.fault[FLT_MCHK] = 1'b1;
      fin_verdict.stat            = '0;
    end
  end

  // ---------------- response register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid    <= 1'b0;
      resp_ok       <= 1'b0;
      resp_pa       <= '0;
      resp_uncached <= 1'b0;
      resp_fault    <= '0;
      resp_status   <= '0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_ok       <= (fin_verdict.fault == '0);
        resp_pa       <= pa_fin;
        resp_uncached <= ev_uncached && (fin_verdict.fault == '0);
        resp_fault    <= fin_verdict.fault;
        resp_status   <= fin_verdict.stat;
      end
    end
  end

  // ---------------- assertions ----------------
  AST_ALIGN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ev_misalign |=> resp_fault == FLT_N'(1 << FLT_ALIGN));  // R1

  AST_PHYS_NO_XLATE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_phys && !ev_misalign |=>
      !resp_fault[FLT_PAGE] && !resp_fault[FLT_ACV] &&
      !resp_fault[FLT_MISS_PTE] && !resp_fault[FLT_MISS_NRM]);  // R2

  AST_BADVA_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_status[MMS_BADVA] |-> resp_fault[FLT_PAGE] && resp_status[MMS_ACV]);  // R3

  AST_SP_KERNEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ev_sp_deny |=> resp_fault[FLT_ACV] && !resp_status[MMS_MISS]);  // R5

  AST_MISS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && (resp_fault[FLT_MISS_PTE] || resp_fault[FLT_MISS_NRM]) |-> resp_status[MMS_MISS]);  // R6

  AST_PERM_BEFORE_FO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && use_perm && ev_perm_deny |=> resp_status[MMS_ACV]);  // R8

  AST_MCHK_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault[FLT_MCHK] |-> resp_status == '0);  // R11

  AST_UC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_uncached |-> resp_ok && resp_pa[UC_BIT] &&
      resp_pa[UC_CLR_HI:UC_CLR_LO] == '0);  // R12

  AST_FAULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $onehot0(resp_fault) && (resp_ok == (resp_fault == '0)));  // R13

  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);  // R13

endmodule

// File: tb/test_dtx_xlate_check.sv
module test_dtx_xlate_check;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WD_CYCLES  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_size_log2 = '0;
  logic        req_store = 1'b0;
  logic        req_phys = 1'b0;
  logic        req_alt = 1'b0;
  logic        req_pte_fetch = 1'b0;
  logic [1:0]  cur_mode = '0;
  logic        priv_code = 1'b0;
  logic [1:0]  alt_mode = '0;
  logic [29:0] lookup_vpn;
  logic        tlb_hit = 1'b0;
  logic [31:0] tlb_ppn = '0;
  logic [3:0]  tlb_rd_en = '0;
  logic [3:0]  tlb_wr_en = '0;
  logic        tlb_fo_rd = 1'b0;
  logic        tlb_fo_wr = 1'b0;
  logic        resp_valid;
  logic        resp_ok;
  logic [63:0] resp_pa;
  logic        resp_uncached;
  logic [5:0]  resp_fault;
  logic [5:0]  resp_status;

  dtx_xlate_check i_dtx_xlate_check (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .req_size_log2(req_size_log2),
    .req_store    (req_store),
    .req_phys     (req_phys),
    .req_alt      (req_alt),
    .req_pte_fetch(req_pte_fetch),
    .cur_mode     (cur_mode),
    .priv_code    (priv_code),
    .alt_mode     (alt_mode),
    .lookup_vpn   (lookup_vpn),
    .tlb_hit      (tlb_hit),
    .tlb_ppn      (tlb_ppn),
    .tlb_rd_en    (tlb_rd_en),
    .tlb_wr_en    (tlb_wr_en),
    .tlb_fo_rd    (tlb_fo_rd),
    .tlb_fo_wr    (tlb_fo_wr),
    .resp_valid   (resp_valid),
    .resp_ok      (resp_ok),
    .resp_pa      (resp_pa),
    .resp_uncached(resp_uncached),
    .resp_fault   (resp_fault),
    .resp_status  (resp_status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [5:0]  f;
    logic [5:0]  s;
    logic [63:0] pa;
    logic        uc;
  } exp_t;

  // expected response, restated from the requirements
  function automatic exp_t model();
    exp_t e;
    logic [63:0] va;
    logic [63:0] pa;
    logic [3:0]  en;
    logic        fo;
    int          m;
    logic [5:0]  wr;
    e.f = '0; e.s = '0; e.pa = '0; e.uc = 1'b0;
    va = req_vaddr;
    wr = {5'b0, req_store};
    if (va % (64'd1 << req_size_log2) != 64'd0) begin
      e.f = 6'b000001; e.s = wr; return e;                 // R1
    end
    if (req_phys) begin
      pa = va;                                             // R2
    end else begin
      if (!((va >> 42) == 64'd0 || (va >> 42) == 64'h3F_FFFF)) begin
        e.f = 6'b000010; e.s = 6'b100010 | wr; return e;   // R3
      end
      if (((va >> 41) & 64'h7f) == 64'h7e) begin
        if (cur_mode != 2'd0) begin
          e.f = 6'b000100; e.s = 6'b000010 | wr; return e; // R5
        end
        pa = va % (64'd1 << 44);                           // R4
        if (pa[40]) pa = pa | (64'hF << 40);
        else        pa = pa % (64'd1 << 40);
      end else if (!tlb_hit) begin
        e.f = req_pte_fetch ? 6'b001000 : 6'b010000;       // R6
        e.s = 6'b010000 | wr; return e;
      end else begin
        pa = 64'(tlb_ppn) * 64'd8192 + va % 64'd8192;      // R7
        m  = priv_code ? (req_alt ? int'(alt_mode) : 0) : int'(cur_mode); // R10
        en = req_store ? tlb_wr_en : tlb_rd_en;
        fo = req_store ? tlb_fo_wr : tlb_fo_rd;
        if (!en[m]) begin                                  // R8
          e.f = req_store ? 6'b000010 : 6'b000100;
          e.s = 6'b000010 | wr | (fo ? (req_store ? 6'b001000 : 6'b000100) : 6'b0);
          return e;
        end
        if (fo) begin                                      // R9
          e.f = 6'b000010;
          e.s = (req_store ? 6'b001000 : 6'b000100) | wr;
          return e;
        end
      end
    end
    if (pa >= (64'd1 << 44)) begin
      e.f = 6'b100000; e.s = '0; return e;                 // R11
    end
    if (pa[43]) begin                                      // R12
      e.uc = 1'b1;
      pa = pa & ~(64'hFF << 35);
    end
    e.pa = pa;
    return e;
  endfunction

  // drive at a falling edge, captured at the next rising edge, sampled at the next falling edge
  task automatic step(input string tag);
    exp_t e;
    req_valid = 1'b1;
    e = model();
    #1;
    n_chk++;
    if (lookup_vpn !== req_vaddr[42:13]) begin
      n_err++;
      $display("FAIL R7 lookup_vpn: actual=%h expected=%h", lookup_vpn, req_vaddr[42:13]);
    end
    @(negedge clk);
    n_chk++;
    if (resp_valid !== 1'b1 || resp_fault !== e.f || resp_status !== e.s ||
        resp_ok !== (e.f == 6'b0) ||
        (e.f == 6'b0 && (resp_pa !== e.pa || resp_uncached !== e.uc))) begin
      n_err++;
      $display("FAIL %s va=%h: actual v=%b fault=%b stat=%b pa=%h uc=%b ok=%b expected fault=%b stat=%b pa=%h uc=%b",
               tag, req_vaddr, resp_valid, resp_fault, resp_status, resp_pa,
               resp_uncached, resp_ok, e.f, e.s, e.pa, e.uc);
    end
  endtask

  function automatic logic [63:0] class_va(input int k);
    case (k)
      0: return 64'h0000_0000_1234_5678;
      1: return 64'hFFFF_FC00_0000_2000;
      2: return 64'hFFFF_FD23_4567_8A00;
      3: return 64'hFFFF_FE00_0000_0000;
      4: return 64'h0001_0000_0000_0000;
      5: return 64'h8000_0000_0000_0040;
      6: return 64'hFFFF_FC80_0000_0008;
      default: return 64'h0000_03FF_FFFF_E000;
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WD_CYCLES; c++) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    // reset: R14
    repeat (3) @(negedge clk);
    n_chk++;
    if (resp_valid !== 1'b0 || resp_fault !== 6'b0) begin
      n_err++;
      $display("FAIL R14 reset: actual v=%b fault=%b expected v=0 fault=000000", resp_valid, resp_fault);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R2: alignment against size, store and physical mode
    tlb_hit = 1'b1; tlb_ppn = 32'h0001_2345; tlb_rd_en = 4'hF; tlb_wr_en = 4'hF;
    for (int sz = 0; sz < 4; sz++)
      for (int lo = 0; lo < 8; lo++)
        for (int st = 0; st < 2; st++)
          for (int ph = 0; ph < 2; ph++) begin
            req_size_log2 = 2'(sz); req_vaddr = 64'h0000_0012_3456_7000 | 64'(lo);
            req_store = st[0]; req_phys = ph[0];
            step("R1/R2");
          end
    req_phys = 1'b0;

    // R8, R9, R10: enables, fault-on bits and mode selection
    req_size_log2 = 2'd3; req_vaddr = 64'h0000_0012_3456_71A8;
    for (int cm = 0; cm < 4; cm++)
      for (int pv = 0; pv < 2; pv++)
        for (int al = 0; al < 2; al++)
          for (int am = 0; am < 4; am++)
            for (int r = 0; r < 16; r++)
              for (int fo = 0; fo < 4; fo++)
                for (int st = 0; st < 2; st++) begin
                  cur_mode = 2'(cm); priv_code = pv[0]; req_alt = al[0]; alt_mode = 2'(am);
                  tlb_rd_en = 4'(r); tlb_wr_en = {tlb_rd_en[1:0], tlb_rd_en[3:2]};
                  tlb_fo_rd = fo[0]; tlb_fo_wr = fo[1]; req_store = st[0];
                  step("R8/R9/R10");
                end
    priv_code = 1'b0; req_alt = 1'b0; tlb_fo_rd = 1'b0; tlb_fo_wr = 1'b0;
    tlb_rd_en = 4'hF; tlb_wr_en = 4'hF;

    // R3, R4, R5, R6: address classes, window, misses
    req_size_log2 = 2'd0;
    for (int k = 0; k < 8; k++)
      for (int cm = 0; cm < 4; cm++)
        for (int st = 0; st < 2; st++)
          for (int h = 0; h < 2; h++)
            for (int pf = 0; pf < 2; pf++) begin
              req_vaddr = class_va(k); cur_mode = 2'(cm); req_store = st[0];
              tlb_hit = h[0]; req_pte_fetch = pf[0];
              step("R3/R4/R5/R6");
            end
    cur_mode = 2'd0; tlb_hit = 1'b1; req_pte_fetch = 1'b0; req_store = 1'b0;

    // R11, R12: physical-mode single bits and uncacheable pattern
    req_phys = 1'b1;
    for (int b = 0; b < 64; b++) begin
      req_vaddr = 64'd1 << b;
      step("R2/R11/R12");
    end
    for (int b = 0; b < 44; b++) begin
      req_vaddr = (64'd1 << 43) | (64'hFF << 35) | (64'd1 << b);
      step("R12");
    end
    req_phys = 1'b0;

    // R7, R11, R12: page number bits on a hit
    req_vaddr = 64'h0000_0000_0000_1FFF;
    for (int k = 0; k < 32; k++) begin
      tlb_ppn = 32'd1 << k;
      step("R7/R11/R12");
    end

    // R13: no request, no response
    req_valid = 1'b0;
    @(negedge clk);
    n_chk++;
    if (resp_valid !== 1'b0) begin
      n_err++;
      $display("FAIL R13 idle: actual v=%b expected v=0", resp_valid);
    end
    finish_run();
  end

endmodule